// File: doc/BRIEF.md
# Interrupt and Handshake-Line Controller

This block is the interrupt section of a peripheral interface adapter. It watches four control lines (two per data port: CA1, CA2 for port A and CB1, CB2 for port B) and raises a flag when the configured edge arrives on any of them. Timer and shift-register events arrive as single-cycle set pulses. Seven flags are held in a flag register. A second register, the enable register, masks them. The interrupt request output is the OR of all enabled flags.

A host reaches three registers through a small register port: the flags, the enables and an 8-bit line-control register. The control register selects the edge polarity of each line. It can also take CA2 or CB2 out of edge detection, or mark that line as an independent interrupt. Each access to a data port (handshake read or write) arrives as a strobe and clears that port's handshake flags. Output pulse generation on the lines and the shift register itself belong to other blocks.

Top module: `irq_hs_ctrl`

## Requirements
- R1: `irq` is high exactly when some bit of (flag & enable) over bits 6:0 is 1. It follows register changes with no added cycle.
- R2: Writing the enable register (`reg_sel`=1) with `wdata[7]`=1 sets each enable bit whose `wdata` bit is 1. With `wdata[7]`=0 it clears each such bit. Bits written as 0 keep their value.
- R3: `rdata` follows `reg_sel` combinationally. Select 0 returns the flag register, 1 returns `{1'b1, enable}`, 2 returns the control register and 3 returns 0x00.
- R4: The flag register has these bit positions: CA2=0, CA1=1, shift=2, CB2=3, CB1=4, timer2=5, timer1=6. A flag read returns bit 7 as 1 when any enabled flag is set, and as 0 otherwise.
- R5: Writing the flag register (`reg_sel`=0) clears every flag whose `wdata` bit is 1 and leaves the others unchanged.
- R6: Control bit 0 picks the CA1 edge and control bit 4 picks the CB1 edge (1 = rising, 0 = falling). A line change sets its flag on the third rising clock edge after the change. An edge of the other polarity sets nothing.
- R7: CA2 sets its flag only while control bit 3 is 0, and control bit 2 picks its edge. CB2 works the same way with bits 7 and 6. When bit 3 (or bit 7) is 1, that line sets no flag.
- R8: A `pa_access` strobe clears the CA1 flag. It also clears the CA2 flag unless control bit 3 is 0 and bit 1 is 1 (independent mode). `pb_access` does the same for CB1 and CB2, using control bits 7 and 5.
- R9: `t1_set`, `t2_set` and `sr_set` pulses set flag bits 6, 5 and 2.
- R10: When a set event and a clear (flag write or port strobe) hit the same flag in one cycle, the flag ends up set.
- R11: Reset clears the flag, enable and control registers, and `irq` is low.
- R12: A control register write (`reg_sel`=2) stores all eight bits, and they read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 flags, 1 enables, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| pa_access | input | 1 | Port A handshake access strobe |
| pb_access | input | 1 | Port B handshake access strobe |
| ca1 | input | 1 | Port A control line 1 (asynchronous) |
| ca2 | input | 1 | Port A control line 2 (asynchronous) |
| cb1 | input | 1 | Port B control line 1 (asynchronous) |
| cb2 | input | 1 | Port B control line 2 (asynchronous) |
| t1_set | input | 1 | Timer 1 flag set pulse |
| t2_set | input | 1 | Timer 2 flag set pulse |
| sr_set | input | 1 | Shift register flag set pulse |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench goes after the CA2 and CB2 independent mode. A design that ignored it would drop the flag on a port access, and a design that misread the bits would keep it in plain handshake mode.

It also covers these cases:
- A set pulse in the same cycle as a flag write that clears the same bit. A design where the clear wins loses that interrupt.
- An enable write with bit 7 clear. A design that loads the value instead of clearing bits wipes unrelated enables.
- Flag reads whose only active flags are disabled. These must show bit 7 low.
- Line edges of the wrong polarity, and the three-edge latency. A wrong design would flag early, flag late, or flag on both edges.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NF    = 7;   // number of flag / enable bits
  localparam int CTL_W = 8;   // control register width
  localparam int NLINE = 4;   // control lines

  // flag bit positions
  localparam int B_CA2 = 0;
  localparam int B_CA1 = 1;
  localparam int B_SR  = 2;
  localparam int B_CB2 = 3;
  localparam int B_CB1 = 4;
  localparam int B_T2  = 5;
  localparam int B_T1  = 6;

  // line indices into the edge detector array
  localparam int L_CA1 = 0;
  localparam int L_CA2 = 1;
  localparam int L_CB1 = 2;
  localparam int L_CB2 = 3;

  typedef enum logic [1:0] {
    SEL_FLAG = 2'd0,
    SEL_EN   = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } sel_e;

  function automatic logic [NF-1:0] enable_next(logic [NF-1:0] cur, logic [7:0] wd);
    return wd[7] ? (cur | wd[NF-1:0]) : (cur & ~wd[NF-1:0]);
  endfunction

  function automatic logic flag_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic logic line_hit(logic rise, logic fall, logic pol);
    return pol ? rise : fall;
  endfunction

  // a "2" line keeps its flag on port access when ctl = {dis=0, ?, ind=1}
  function automatic logic indep_mode(logic dis_bit, logic ind_bit);
    return !dis_bit && ind_bit;
  endfunction

  function automatic logic [NF-1:0] hs_clear(logic [CTL_W-1:0] ctl, logic pa, logic pb);
    logic [NF-1:0] m;
    m = '0;
    if (pa) begin
      m[B_CA1] = 1'b1;
      m[B_CA2] = !indep_mode(ctl[3], ctl[1]);
    end
    if (pb) begin
      m[B_CB1] = 1'b1;
      m[B_CB2] = !indep_mode(ctl[7], ctl[5]);
    end
    return m;
  endfunction
endpackage

// File: rtl/irqc_edge.sv
module irqc_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  // sh[0..STAGES-1] synchroniser, sh[STAGES] previous synchronised value
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign rise =  sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/irqc_flags.sv
module irqc_flags
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_evt,
  input  logic [NF-1:0] clr_evt,
  input  logic          en_wr,
  input  logic [7:0]    wdata,
  output logic [NF-1:0] flag_q,
  output logic [NF-1:0] en_q
);
  logic [NF-1:0] flag_d;

  for (genvar i = 0; i < NF; i++) begin : g_bit
    assign flag_d[i] = flag_next(flag_q[i], set_evt[i], clr_evt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      en_q   <= '0;
    end else begin
      flag_q <= flag_d;
      if (en_wr) en_q <= enable_next(en_q, wdata);
    end
  end
endmodule

// File: rtl/irq_hs_ctrl.sv
module irq_hs_ctrl
  import irqc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       pa_access,
  input  logic       pb_access,
  input  logic       ca1,
  input  logic       ca2,
  input  logic       cb1,
  input  logic       cb2,
  input  logic       t1_set,
  input  logic       t2_set,
  input  logic       sr_set,
  output logic       irq
);
  logic [NLINE-1:0] line_in, rise, fall;
  logic [CTL_W-1:0] ctl_q;
  logic [NF-1:0]    set_evt, clr_evt, flag_q, en_q;
  logic             flag_wr, en_wr, ctl_wr, any_on;

  assign line_in = {cb2, cb1, ca2, ca1};

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    irqc_edge #(.STAGES(2)) u_edge (
      .clk (clk), .rst_n (rst_n), .din (line_in[l]),
      .rise(rise[l]), .fall(fall[l])
    );
  end

  assign flag_wr = reg_wr && (reg_sel == SEL_FLAG);
  assign en_wr   = reg_wr && (reg_sel == SEL_EN);
  assign ctl_wr  = reg_wr && (reg_sel == SEL_CTL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_wr) ctl_q <= wdata;
  end

  always_comb begin
    set_evt        = '0;
    set_evt[B_CA1] = line_hit(rise[L_CA1], fall[L_CA1], ctl_q[0]);
    set_evt[B_CA2] = !ctl_q[3] && line_hit(rise[L_CA2], fall[L_CA2], ctl_q[2]);
    set_evt[B_CB1] = line_hit(rise[L_CB1], fall[L_CB1], ctl_q[4]);
    set_evt[B_CB2] = !ctl_q[7] && line_hit(rise[L_CB2], fall[L_CB2], ctl_q[6]);
    set_evt[B_SR]  = sr_set;
    set_evt[B_T2]  = t2_set;
    set_evt[B_T1]  = t1_set;
  end

  assign clr_evt = (flag_wr ? wdata[NF-1:0] : '0) | hs_clear(ctl_q, pa_access, pb_access);

  irqc_flags u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_evt(set_evt),
    .clr_evt(clr_evt),
    .en_wr  (en_wr),
    .wdata  (wdata),
    .flag_q (flag_q),
    .en_q   (en_q)
  );

  assign any_on = |(flag_q & en_q);
  assign irq    = any_on;

  always_comb begin
    unique case (sel_e'(reg_sel))
      SEL_FLAG: rdata = {any_on, flag_q};
      SEL_EN:   rdata = {1'b1, en_q};
      SEL_CTL:  rdata = ctl_q;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_hs_ctrl_chk.sv
module irq_hs_ctrl_chk
  import irqc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [1:0]       reg_sel,
  input logic [7:0]       wdata,
  input logic [7:0]       rdata,
  input logic             pa_access,
  input logic             irq,
  input logic [NF-1:0]    flag_q,
  input logic [NF-1:0]    en_q,
  input logic [CTL_W-1:0] ctl_q,
  input logic [NF-1:0]    set_evt
);
  logic en_wr_c, flag_wr_c;
  assign en_wr_c   = reg_wr && (reg_sel == 2'd1);
  assign flag_wr_c = reg_wr && (reg_sel == 2'd0);

  a_r1_enabled_set_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & en_q) != '0 && !en_wr_c) |=> irq);

  a_r2_enable_set: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_c && wdata[7]) |=> ((en_q & $past(wdata[NF-1:0])) == $past(wdata[NF-1:0])));

  a_r2_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr_c && !wdata[7]) |=> ((en_q & $past(wdata[NF-1:0])) == '0));

  a_r3_enable_read_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == 2'd1) |-> rdata[7]);

  a_r5_flag_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr_c && set_evt == '0) |=> ((flag_q & $past(wdata[NF-1:0])) == '0));

  a_r7_ca2_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[3] |-> !set_evt[B_CA2]);

  a_r8_pa_clears_ca1: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_access && !set_evt[B_CA1]) |=> !flag_q[B_CA1]);

  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt != '0) |=> ((flag_q & $past(set_evt)) == $past(set_evt)));
endmodule

bind irq_hs_ctrl irq_hs_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_wr   (reg_wr),
  .reg_sel  (reg_sel),
  .wdata    (wdata),
  .rdata    (rdata),
  .pa_access(pa_access),
  .irq      (irq),
  .flag_q   (flag_q),
  .en_q     (en_q),
  .ctl_q    (ctl_q),
  .set_evt  (set_evt)
);

// File: tb/sim_irq_hs_ctrl.sv
module sim_irq_hs_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       pa_access = 1'b0, pb_access = 1'b0;
  logic       ca1 = 1'b0, ca2 = 1'b0, cb1 = 1'b0, cb2 = 1'b0;
  logic       t1_set = 1'b0, t2_set = 1'b0, sr_set = 1'b0;
  logic       irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_hs_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .wdata(wdata), .rdata(rdata), .pa_access(pa_access), .pb_access(pb_access),
    .ca1(ca1), .ca2(ca2), .cb1(cb1), .cb2(cb2),
    .t1_set(t1_set), .t2_set(t2_set), .sr_set(sr_set), .irq(irq)
  );

  // ---------------- reference model, built from the requirements ----------------
  logic [6:0] m_flag, m_en;
  logic [7:0] m_ctl;
  logic [3:0] m_s1, m_s2, m_pv;   // line order: ca1, ca2, cb1, cb2

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_flag = '0; m_en = '0; m_ctl = '0;
      m_s1 = '0; m_s2 = '0; m_pv = '0;
    end else begin
      logic [3:0] up, dn;
      logic [6:0] setm, clrm;
      up = m_s2 & ~m_pv;
      dn = ~m_s2 & m_pv;
      setm = '0;
      setm[1] = m_ctl[0] ? up[0] : dn[0];                    // CA1 (R6)
      setm[0] = (m_ctl[3] == 1'b0) && (m_ctl[2] ? up[1] : dn[1]); // CA2 (R7)
      setm[4] = m_ctl[4] ? up[2] : dn[2];                    // CB1 (R6)
      setm[3] = (m_ctl[7] == 1'b0) && (m_ctl[6] ? up[3] : dn[3]); // CB2 (R7)
      setm[6] = t1_set; setm[5] = t2_set; setm[2] = sr_set;  // R9
      clrm = '0;
      if (reg_wr && reg_sel == 2'd0) clrm = wdata[6:0];      // R5
      if (pa_access) begin                                   // R8
        clrm[1] = 1'b1;
        if (!(m_ctl[3] == 1'b0 && m_ctl[1] == 1'b1)) clrm[0] = 1'b1;
      end
      if (pb_access) begin
        clrm[4] = 1'b1;
        if (!(m_ctl[7] == 1'b0 && m_ctl[5] == 1'b1)) clrm[3] = 1'b1;
      end
      m_flag = (m_flag & ~clrm) | setm;                      // R10
      if (reg_wr && reg_sel == 2'd1)                         // R2
        for (int i = 0; i < 7; i++)
          if (wdata[i]) m_en[i] = wdata[7];
      if (reg_wr && reg_sel == 2'd2) m_ctl = wdata;          // R12
      m_pv = m_s2; m_s2 = m_s1; m_s1 = {cb2, cb1, ca2, ca1};
    end
  end

  function automatic logic [7:0] exp_read(logic [1:0] s);
    case (s)
      2'd0:    return {((m_flag & m_en) != 0), m_flag};
      2'd1:    return {1'b1, m_en};
      2'd2:    return m_ctl;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_model();
    check("R1 irq", {7'd0, irq}, {7'd0, ((m_flag & m_en) != 0)});
    case (reg_sel)
      2'd0:    check("R4 flag read", rdata, exp_read(reg_sel));
      2'd1:    check("R3 enable read", rdata, exp_read(reg_sel));
      2'd2:    check("R12 control read", rdata, exp_read(reg_sel));
      default: check("R3 unused select", rdata, exp_read(reg_sel));
    endcase
  endtask

  // advance one clock, compare against model, drop single-cycle strobes
  task automatic step();
    @(negedge clk);
    compare_model();
    reg_wr = 0; pa_access = 0; pb_access = 0; t1_set = 0; t2_set = 0; sr_set = 0;
  endtask

  task automatic wr(logic [1:0] s, logic [7:0] d);
    reg_wr = 1; reg_sel = s; wdata = d; step();
  endtask

  task automatic peek(string tag, logic [1:0] s, logic [7:0] exp);
    reg_sel = s; #1; check(tag, rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 reset state
    peek("R11 flags after reset", 2'd0, 8'h00);
    peek("R11 enables after reset", 2'd1, 8'h80);
    peek("R11 control after reset", 2'd2, 8'h00);
    check("R11 irq after reset", {7'd0, irq}, 8'h00);

    wr(2'd1, 8'hFF);  peek("R2 enable set all", 2'd1, 8'hFF);
    wr(2'd1, 8'h05);  peek("R2 enable clear bits 0,2", 2'd1, 8'hFA);
    reg_sel = 2'd0; t1_set = 1; step();
    peek("R9 timer1 sets bit 6", 2'd0, 8'hC0);
    check("R1 irq on enabled flag", {7'd0, irq}, 8'h01);
    t1_set = 1; wr(2'd0, 8'h40);
    peek("R10 set beats flag-write clear", 2'd0, 8'hC0);
    wr(2'd0, 8'h40);
    peek("R5 flag write clears", 2'd0, 8'h00);
    check("R1 irq drops", {7'd0, irq}, 8'h00);
    wr(2'd1, 8'h7F);
    t2_set = 1; step();
    peek("R4 summary low for disabled flag", 2'd0, 8'h20);
    check("R1 no irq when disabled", {7'd0, irq}, 8'h00);
    wr(2'd0, 8'h7F);
    wr(2'd1, 8'hFF);

    // R6: CA1 falling edge selected (ctl bit0 = 0)
    ca1 = 1; repeat (4) step();
    peek("R6 CA1 rising ignored when falling selected", 2'd0, 8'h00);
    ca1 = 0; step(); step();
    peek("R6 CA1 not yet set after two edges", 2'd0, 8'h00);
    step();
    peek("R6 CA1 set on third edge", 2'd0, 8'h82);
    pa_access = 1; step();
    peek("R8 port A access clears CA1", 2'd0, 8'h00);

    // R8: CA2 independent mode keeps flag (ctl = 0x06: rising, independent)
    wr(2'd2, 8'h06);
    ca2 = 1; repeat (4) step();
    peek("R7 CA2 rising edge sets bit 0", 2'd0, 8'h81);
    pa_access = 1; step();
    peek("R8 CA2 kept in independent mode", 2'd0, 8'h81);
    wr(2'd2, 8'h04);
    pa_access = 1; step();
    peek("R8 CA2 cleared in handshake mode", 2'd0, 8'h00);

    // R7: CA2 edge detection off when ctl bit3 = 1
    wr(2'd2, 8'h0C);
    ca2 = 0; repeat (2) step(); ca2 = 1; repeat (4) step();
    peek("R7 CA2 disabled sets nothing", 2'd0, 8'h00);

    // R6/R8: CB1 rising, cleared by port B access
    wr(2'd2, 8'h10);
    cb1 = 1; repeat (4) step();
    peek("R6 CB1 rising sets bit 4", 2'd0, 8'h90);
    pb_access = 1; step();
    peek("R8 port B access clears CB1", 2'd0, 8'h00);

    // R7/R8: CB2 independent mode with falling edge (ctl = 0x20)
    wr(2'd2, 8'h20);
    cb2 = 1; repeat (4) step(); cb2 = 0; repeat (4) step();
    peek("R7 CB2 falling sets bit 3", 2'd0, 8'h88);
    pb_access = 1; step();
    peek("R8 CB2 kept in independent mode", 2'd0, 8'h88);
    wr(2'd0, 8'h08);

    // constrained random phase, checked every cycle against the model
    for (int n = 0; n < 4000; n++) begin
      reg_sel   = 2'($urandom % 4);
      reg_wr    = ($urandom % 4) == 0;
      wdata     = 8'($urandom);
      pa_access = ($urandom % 8) == 0;
      pb_access = ($urandom % 8) == 0;
      t1_set    = ($urandom % 6) == 0;
      t2_set    = ($urandom % 6) == 0;
      sr_set    = ($urandom % 6) == 0;
      if (($urandom % 5) == 0) ca1 = ~ca1;
      if (($urandom % 5) == 0) ca2 = ~ca2;
      if (($urandom % 5) == 0) cb1 = ~cb1;
      if (($urandom % 5) == 0) cb2 = ~cb2;
      step();
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule